// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block sits between a 32-bit transmit queue, a 32-bit receive queue and a byte-wide SPI shifter. It pops words from the transmit queue and sends each one as a series of bytes, lowest byte first. It collects the bytes that come back into receive words and pushes them, or reports an overflow when the receive queue is full. A signed count of the bits left in the current burst decides how many bytes each word carries. A burst can therefore cover several words, or only part of one.

The control fields come from the surrounding register block. They are the burst-length field, the start-mode bit, the per-channel master bits, the per-channel slave-select wave bits and the selected channel. Three start events begin a drain:
- a transmit write while the start-mode bit is set;
- a rising start-mode bit while the transmit queue holds data;
- a write of the exchange bit while the start-mode bit is clear.

All three events require the selected channel to be a master. The block owns the exchange bit and pulses the transfer-complete and overflow status bits. In multiple-burst mode it keeps draining across burst boundaries. The mode applies when the channel is master, the start-mode bit is clear and the channel's wave bit is set.

The state machine has five states:
- IDLE waits for a start event.
- FETCH pops a word. If the remaining count is zero or below, FETCH also reloads it. If the queue is empty, FETCH finishes instead.
- ISSUE raises a one-cycle byte request.
- WAIT holds until the shifter's done pulse. It then goes back to ISSUE for the next byte, or on to STORE after the last byte of the word.
- STORE pushes the received word or flags an overflow. It then returns to FETCH, or to IDLE at the end of a burst outside multiple-burst mode.

Dropping `enable` or pulsing `soft_rst` forces IDLE from any state.

Top module: `spi_burst_seq`

## Requirements
- R1: The burst length in bits is the burst-length field plus one. It is loaded only in FETCH when the remaining count is zero or below, so a 64-bit burst spans two words without reloading.
- R2: Each popped word sends ceil(min(remaining, 32)/8) bytes, and the count drops by 8 per byte. A 12-bit burst sends 2 bytes. A 40-bit burst sends 4 bytes, then 1 byte.
- R3: The bytes of a transmit word go out on `byte_out` least significant byte first.
- R4: The i-th byte received for a word is placed at bits [8i+7:8i] of `rx_data`. Bytes that were not exchanged read as zero.
- R5: When a word completes while `rx_full` is high, `ro_set` pulses and `rx_push` stays low. Otherwise `rx_push` pulses.
- R6: Outside multiple-burst mode, the end of a burst pulses `tc_set` and returns to IDLE, even if the transmit queue still holds data. In that case `xch` stays set.
- R7: Finding the transmit queue empty in FETCH, or at the end of a burst, pulses `tc_set` and clears `xch`.
- R8: In multiple-burst mode, bursts follow one another without stopping until the queue is empty. `xch` is set on each burst load.
- R9: Draining starts only on the three start events. A transmit write with the start-mode bit clear does not start it, and neither does any event on a non-master channel.
- R10: Each byte uses one request pulse. No new request is issued until the shifter's done pulse for the previous one.
- R11: Low `enable` or a `soft_rst` pulse aborts the transfer, returns to IDLE, clears `xch` and zeroes the remaining count. The next start therefore reloads the burst length.
- R12: After reset the block is idle, with `busy`, `xch`, `byte_req`, `tx_pop` and `rx_push` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts |
| soft_rst | input | 1 | Pulse that aborts the transfer |
| ctl_len | input | LEN_W | Burst-length field (bits minus one) |
| ctl_smc | input | 1 | Start-mode bit: start on write |
| ctl_chan_master | input | N_CHAN | Master bit per channel |
| ctl_ss_wave | input | N_CHAN | Slave-select wave bit per channel |
| ctl_chan_sel | input | CSW | Selected channel |
| tx_write | input | 1 | Pulse: a word was written to the transmit queue |
| xch_wr | input | 1 | Pulse: software set the exchange bit |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | WORD_W | Head word of the transmit queue (show-ahead) |
| tx_pop | output | 1 | Pop the transmit queue |
| rx_full | input | 1 | Receive queue full |
| rx_push | output | 1 | Push `rx_data` into the receive queue |
| rx_data | output | WORD_W | Assembled receive word |
| byte_req | output | 1 | Request one byte exchange |
| byte_out | output | 8 | Byte to send |
| byte_done | input | 1 | Shifter finished the exchange |
| byte_in | input | 8 | Byte received, valid with `byte_done` |
| xch | output | 1 | Exchange bit |
| tc_set | output | 1 | Pulse that sets transfer complete |
| ro_set | output | 1 | Pulse that sets receive overflow |
| busy | output | 1 | State is not IDLE |

## Verification
The hardest cases to reach are those where the remaining-bit count is not aligned to word boundaries. The stimulus drives them by choosing burst fields such as 11, 39 and 63 and queuing several words before a single start. The bench then counts bytes per word and pushes per burst. The abort case needs the count to be left mid-burst. The bench aborts after two bytes of a 256-bit burst and then starts a 16-bit burst: a count that was not cleared would send 4 bytes instead of 2. Early stop outside multiple-burst mode leaves a word queued while `xch` stays set, and a second exchange write then drains that word.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_WAIT,
        ST_STORE
    } seq_state_e;
endpackage

// File: rtl/spi_mode_decode.sv
module spi_mode_decode #(
    parameter int N_CHAN = 4,
    parameter int CSW    = $clog2(N_CHAN)
) (
    input  logic [N_CHAN-1:0] chan_master,
    input  logic [N_CHAN-1:0] ss_wave,
    input  logic [CSW-1:0]    chan_sel,
    input  logic              smc,
    output logic              is_master,
    output logic              multi_burst
);
    always_comb begin
        is_master   = chan_master[chan_sel];
        multi_burst = chan_master[chan_sel] && !smc && ss_wave[chan_sel];
    end
endmodule

// File: rtl/spi_bit_budget.sv
module spi_bit_budget #(
    parameter int LEN_W  = 12,
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          load,
    input  logic                          dec,
    input  logic [LEN_W-1:0]              len_field,
    output logic                          exhausted,
    output logic [$clog2(WORD_W/8):0]     span_bytes
);
    localparam int CW   = LEN_W + 2;
    localparam int BCW  = $clog2(WORD_W/8) + 1;
    localparam logic signed [CW-1:0] ONE   = 1;
    localparam logic signed [CW-1:0] EIGHT = 8;
    localparam logic signed [CW-1:0] WBITS = WORD_W;

    logic signed [CW-1:0] rem_q;
    logic signed [CW-1:0] eff;
    logic        [CW-1:0] span_u;
    logic        [CW-1:0] round_u;

    always_comb begin
        exhausted  = (rem_q <= 0);
        eff        = exhausted ? ($signed({2'b00, len_field}) + ONE) : rem_q;
        span_u     = (eff > WBITS) ? WBITS : eff;
        round_u    = (span_u + CW'(7)) >> 3;
        span_bytes = round_u[BCW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (clr)
            rem_q <= '0;
        else if (load)
            rem_q <= eff;
        else if (dec)
            rem_q <= rem_q - EIGHT;
    end
endmodule

// File: rtl/spi_word_pack.sv
module spi_word_pack #(
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [WORD_W-1:0]              tx_word,
    input  logic                           shift_en,
    input  logic [7:0]                     byte_in,
    output logic [7:0]                     byte_out,
    output logic [WORD_W-1:0]              rx_word,
    output logic [$clog2(WORD_W/8)-1:0]    idx
);
    localparam int IW = $clog2(WORD_W/8);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] rx_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= tx_word;
            rx_q  <= '0;
            idx_q <= '0;
        end else if (shift_en) begin
            sh_q                  <= sh_q >> 8;
            rx_q[{idx_q, 3'b000} +: 8] <= byte_in;
            idx_q                 <= idx_q + IW'(1);
        end
    end

    assign byte_out = sh_q[7:0];
    assign rx_word  = rx_q;
    assign idx      = idx_q;
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int N_CHAN = 4,
    parameter int LEN_W  = 12,
    parameter int WORD_W = 32,
    parameter int CSW    = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              soft_rst,
    input  logic [LEN_W-1:0]  ctl_len,
    input  logic              ctl_smc,
    input  logic [N_CHAN-1:0] ctl_chan_master,
    input  logic [N_CHAN-1:0] ctl_ss_wave,
    input  logic [CSW-1:0]    ctl_chan_sel,
    input  logic              tx_write,
    input  logic              xch_wr,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              byte_req,
    output logic [7:0]        byte_out,
    input  logic              byte_done,
    input  logic [7:0]        byte_in,
    output logic              xch,
    output logic              tc_set,
    output logic              ro_set,
    output logic              busy
);
    localparam int IW  = $clog2(WORD_W/8);
    localparam int BCW = IW + 1;

    seq_state_e state_q, state_d;

    logic           is_master, multi_burst;
    logic           abort;
    logic           start;
    logic           smc_q;
    logic           xch_q;
    logic           exhausted;
    logic [BCW-1:0] span_bytes;
    logic [BCW-1:0] nbytes_q;
    logic [IW-1:0]  idx;
    logic           last_byte;

    logic budget_load, budget_dec;
    logic pack_load;
    logic xch_mb_set, xch_clr;

    spi_mode_decode #(.N_CHAN(N_CHAN), .CSW(CSW)) u_mode (
        .chan_master (ctl_chan_master),
        .ss_wave     (ctl_ss_wave),
        .chan_sel    (ctl_chan_sel),
        .smc         (ctl_smc),
        .is_master   (is_master),
        .multi_burst (multi_burst)
    );

    spi_bit_budget #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (abort),
        .load       (budget_load),
        .dec        (budget_dec),
        .len_field  (ctl_len),
        .exhausted  (exhausted),
        .span_bytes (span_bytes)
    );

    spi_word_pack #(.WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pack_load),
        .tx_word  (tx_data),
        .shift_en (budget_dec),
        .byte_in  (byte_in),
        .byte_out (byte_out),
        .rx_word  (rx_data),
        .idx      (idx)
    );

    assign abort     = !enable || soft_rst;
    assign last_byte = ((BCW'(idx) + BCW'(1)) == nbytes_q);
    assign start     = is_master && (
                           (tx_write && ctl_smc) ||
                           (ctl_smc && !smc_q && !tx_empty) ||
                           (xch_wr && !ctl_smc));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (abort)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and output strobes
    always_comb begin
        state_d     = state_q;
        tx_pop      = 1'b0;
        pack_load   = 1'b0;
        budget_load = 1'b0;
        budget_dec  = 1'b0;
        byte_req    = 1'b0;
        rx_push     = 1'b0;
        ro_set      = 1'b0;
        tc_set      = 1'b0;
        xch_mb_set  = 1'b0;
        xch_clr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (tx_empty) begin
                    tc_set  = 1'b1;
                    xch_clr = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    tx_pop    = 1'b1;
                    pack_load = 1'b1;
                    if (exhausted) begin
                        budget_load = 1'b1;
                        xch_mb_set  = multi_burst;
                    end
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                byte_req = 1'b1;
                state_d  = ST_WAIT;
            end
            ST_WAIT: begin
                if (byte_done) begin
                    budget_dec = 1'b1;
                    state_d    = last_byte ? ST_STORE : ST_ISSUE;
                end
            end
            ST_STORE: begin
                if (rx_full)
                    ro_set = 1'b1;
                else
                    rx_push = 1'b1;
                if (exhausted && !multi_burst) begin
                    tc_set  = 1'b1;
                    xch_clr = tx_empty;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            tx_pop      = 1'b0;
            pack_load   = 1'b0;
            budget_load = 1'b0;
            budget_dec  = 1'b0;
            byte_req    = 1'b0;
            rx_push     = 1'b0;
            ro_set      = 1'b0;
            tc_set      = 1'b0;
            xch_mb_set  = 1'b0;
            xch_clr     = 1'b0;
        end
    end

    // number of bytes for the word being sent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nbytes_q <= '0;
        else if (pack_load)
            nbytes_q <= span_bytes;
    end

    // exchange bit and start-mode edge tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xch_q <= 1'b0;
            smc_q <= 1'b0;
        end else if (abort) begin
            xch_q <= 1'b0;
            smc_q <= 1'b0;
        end else begin
            smc_q <= ctl_smc;
            if (xch_clr)
                xch_q <= 1'b0;
            else if (xch_wr || xch_mb_set)
                xch_q <= 1'b1;
        end
    end

    assign xch  = xch_q;
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/spi_burst_seq_chk.sv
module spi_burst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic soft_rst,
    input logic tx_empty,
    input logic tx_pop,
    input logic rx_full,
    input logic rx_push,
    input logic byte_req,
    input logic byte_done,
    input logic xch,
    input logic tc_set,
    input logic ro_set,
    input logic busy
);
    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (!enable || soft_rst)
            pending_q <= 1'b0;
        else if (byte_req)
            pending_q <= 1'b1;
        else if (byte_done)
            pending_q <= 1'b0;
    end

    assert_one_req_per_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !pending_q);

    assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    assert_ovf_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ro_set |-> (rx_full && !rx_push));

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || soft_rst) |=> (!busy && !xch));

    assert_empty_clears_xch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set && tx_empty) |=> !xch);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!byte_req && !tx_pop && !rx_push && !ro_set));
endmodule

bind spi_burst_seq spi_burst_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .soft_rst  (soft_rst),
    .tx_empty  (tx_empty),
    .tx_pop    (tx_pop),
    .rx_full   (rx_full),
    .rx_push   (rx_push),
    .byte_req  (byte_req),
    .byte_done (byte_done),
    .xch       (xch),
    .tc_set    (tc_set),
    .ro_set    (ro_set),
    .busy      (busy)
);

// File: tb/spi_burst_seq_bench.sv
module spi_burst_seq_bench;
    localparam int N_CHAN = 4;
    localparam int LEN_W  = 12;
    localparam int WORD_W = 32;
    localparam int CSW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, soft_rst = 1'b0;
    logic [LEN_W-1:0] ctl_len = '0;
    logic ctl_smc = 1'b0;
    logic [N_CHAN-1:0] ctl_chan_master = '0, ctl_ss_wave = '0;
    logic [CSW-1:0] ctl_chan_sel = '0;
    logic tx_write = 1'b0, xch_wr = 1'b0;
    logic tx_empty, tx_pop, rx_full = 1'b0, rx_push;
    logic [WORD_W-1:0] tx_data, rx_data;
    logic byte_req, byte_done = 1'b0;
    logic [7:0] byte_out, byte_in = '0;
    logic xch, tc_set, ro_set, busy;

    always #5 clk = ~clk;

    spi_burst_seq u_spi_burst_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
        .ctl_len(ctl_len), .ctl_smc(ctl_smc), .ctl_chan_master(ctl_chan_master),
        .ctl_ss_wave(ctl_ss_wave), .ctl_chan_sel(ctl_chan_sel),
        .tx_write(tx_write), .xch_wr(xch_wr), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .byte_req(byte_req),
        .byte_out(byte_out), .byte_done(byte_done), .byte_in(byte_in),
        .xch(xch), .tc_set(tc_set), .ro_set(ro_set), .busy(busy)
    );

    // transmit queue model (show-ahead)
    logic [31:0] txq [0:63];
    int tx_wp = 0;
    int tx_rp = 0;
    assign tx_empty = (tx_wp == tx_rp);
    assign tx_data  = txq[tx_rp % 64];

    // logs
    logic [7:0]  sent_log [0:255];
    logic [31:0] rx_log   [0:63];
    int n_req = 0, n_push = 0, n_tc = 0, n_ro = 0, hs_err = 0;
    int sh_cnt = 0;

    always @(posedge clk) begin
        if (tx_pop) tx_rp <= tx_rp + 1;
        if (rx_push) begin
            rx_log[n_push % 64] <= rx_data;
            n_push <= n_push + 1;
        end
        if (tc_set) n_tc <= n_tc + 1;
        if (ro_set) n_ro <= n_ro + 1;
        byte_done <= (sh_cnt == 1);
        if (sh_cnt != 0) sh_cnt <= sh_cnt - 1;
        if (byte_req) begin
            if (sh_cnt != 0) hs_err <= hs_err + 1;
            sent_log[n_req % 256] <= byte_out;
            byte_in <= byte_out ^ 8'h5A;
            n_req  <= n_req + 1;
            sh_cnt <= 2;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w, input bit strobe);
        @(negedge clk);
        txq[tx_wp % 64] = w;
        tx_wp = tx_wp + 1;
        tx_write = strobe;
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic pulse_xch();
        @(negedge clk);
        xch_wr = 1'b1;
        @(negedge clk);
        xch_wr = 1'b0;
    endtask

    task automatic wait_idle();
        cyc(3);
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        cyc(2);
    endtask

    task automatic t_reset();
        chk(!busy && !xch && !byte_req && !tx_pop && !rx_push, "R12 reset idle",
            {busy, xch, byte_req, tx_pop, rx_push}, 0);
    endtask

    task automatic t_single_word();
        int b0, p0, c0;
        b0 = n_req; p0 = n_push; c0 = n_tc;
        ctl_len = 12'd31; ctl_smc = 1'b1;
        push_word(32'h4433_2211, 1'b1);
        wait_idle();
        chk(n_req - b0 == 4, "R2 bytes per 32-bit word", n_req - b0, 4);
        chk({sent_log[b0+3], sent_log[b0+2], sent_log[b0+1], sent_log[b0]} == 32'h4433_2211,
            "R3 LSB first", {sent_log[b0+3], sent_log[b0+2], sent_log[b0+1], sent_log[b0]}, 32'h4433_2211);
        chk(n_push - p0 == 1 && rx_log[p0 % 64] == (32'h4433_2211 ^ 32'h5A5A_5A5A),
            "R4 rx assembly", rx_log[p0 % 64], 32'h4433_2211 ^ 32'h5A5A_5A5A);
        chk(n_tc - c0 == 1 && !xch, "R7 tc on empty", n_tc - c0, 1);
    endtask

    task automatic t_short_burst();
        int b0, p0;
        b0 = n_req; p0 = n_push;
        ctl_len = 12'd11; ctl_smc = 1'b1;
        push_word(32'hDDCC_BBAA, 1'b1);
        wait_idle();
        chk(n_req - b0 == 2, "R2 12-bit burst bytes", n_req - b0, 2);
        chk(rx_log[p0 % 64] == 32'h0000_E1F0, "R4 unsent bytes zero", rx_log[p0 % 64], 32'h0000_E1F0);
    endtask

    task automatic t_cross_word();
        int b0, p0, c0;
        ctl_smc = 1'b0; ctl_len = 12'd63;
        b0 = n_req; p0 = n_push; c0 = n_tc;
        push_word(32'h0403_0201, 1'b0);
        push_word(32'h0807_0605, 1'b0);
        pulse_xch();
        wait_idle();
        chk(n_req - b0 == 8 && n_push - p0 == 2, "R1 64-bit burst across two words", n_req - b0, 8);
        chk(sent_log[b0+4] == 8'h05, "R3 second word LSB", sent_log[b0+4], 8'h05);
        chk(n_tc - c0 == 1 && !xch, "R7 one tc, xch cleared", n_tc - c0, 1);
        ctl_len = 12'd39;
        b0 = n_req; p0 = n_push;
        push_word(32'h1111_1111, 1'b0);
        push_word(32'h2222_2222, 1'b0);
        pulse_xch();
        wait_idle();
        chk(n_req - b0 == 5 && n_push - p0 == 2, "R2 40-bit burst 4+1 bytes", n_req - b0, 5);
        chk(rx_log[(p0+1) % 64] == 32'h0000_0078, "R4 partial second word", rx_log[(p0+1) % 64], 32'h78);
    endtask

    task automatic t_stop_early();
        int b0, c0;
        ctl_smc = 1'b0; ctl_len = 12'd7;
        b0 = n_req; c0 = n_tc;
        push_word(32'h0000_00A1, 1'b0);
        push_word(32'h0000_00B2, 1'b0);
        pulse_xch();
        wait_idle();
        chk(n_req - b0 == 1 && n_tc - c0 == 1, "R6 stop at burst end", n_req - b0, 1);
        chk(tx_wp - tx_rp == 1 && xch, "R6 word left, xch held", tx_wp - tx_rp, 1);
        pulse_xch();
        wait_idle();
        chk(n_req - b0 == 2 && sent_log[b0+1] == 8'hB2 && !xch, "R7 drained, xch cleared",
            sent_log[b0+1], 8'hB2);
    endtask

    task automatic t_multi_burst();
        int b0, p0, c0;
        bit mid_ok;
        ctl_smc = 1'b0; ctl_len = 12'd7; ctl_ss_wave = 4'b0001;
        b0 = n_req; p0 = n_push; c0 = n_tc;
        push_word(32'h0000_0031, 1'b0);
        push_word(32'h0000_0032, 1'b0);
        push_word(32'h0000_0033, 1'b0);
        pulse_xch();
        for (int i = 0; i < 500 && (n_req - b0) < 2; i++) @(negedge clk);
        mid_ok = busy && xch;
        chk(mid_ok, "R8 xch held between bursts", {busy, xch}, 2'b11);
        wait_idle();
        chk(n_req - b0 == 3 && n_push - p0 == 3, "R8 three bursts without stop", n_req - b0, 3);
        chk(n_tc - c0 == 1 && !xch, "R8 single tc at empty", n_tc - c0, 1);
        ctl_ss_wave = 4'b0000;
    endtask

    task automatic t_overflow();
        int p0, r0;
        ctl_smc = 1'b1; ctl_len = 12'd31; rx_full = 1'b1;
        p0 = n_push; r0 = n_ro;
        push_word(32'hCAFE_F00D, 1'b1);
        wait_idle();
        chk(n_ro - r0 == 1 && n_push == p0, "R5 overflow discards word", n_ro - r0, 1);
        rx_full = 1'b0;
    endtask

    task automatic t_start_events();
        int b0;
        ctl_smc = 1'b0; ctl_len = 12'd31;
        b0 = n_req;
        push_word(32'h5555_6666, 1'b1);
        cyc(10);
        chk(n_req == b0 && !busy, "R9 write with smc clear ignored", n_req - b0, 0);
        ctl_chan_master = 4'b0000;
        pulse_xch();
        cyc(10);
        chk(n_req == b0 && !busy, "R9 non-master exchange ignored", n_req - b0, 0);
        ctl_chan_master = 4'b0001;
        @(negedge clk); ctl_smc = 1'b1;
        wait_idle();
        chk(n_req - b0 == 4 && sent_log[b0] == 8'h66, "R9 smc rise starts", n_req - b0, 4);
    endtask

    task automatic t_abort();
        int b0;
        ctl_smc = 1'b1; ctl_len = 12'd255;
        b0 = n_req;
        push_word(32'h8877_6655, 1'b1);
        for (int i = 0; i < 500 && (n_req - b0) < 2; i++) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy && !xch, "R11 disable aborts", busy, 0);
        enable = 1'b1;
        cyc(8);
        ctl_len = 12'd15;
        b0 = n_req;
        push_word(32'h0000_BEEF, 1'b1);
        wait_idle();
        chk(n_req - b0 == 2, "R11 count cleared on abort", n_req - b0, 2);
        // soft reset mid-word
        ctl_len = 12'd31;
        b0 = n_req;
        push_word(32'h0102_0304, 1'b1);
        for (int i = 0; i < 500 && (n_req - b0) < 1; i++) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(!busy, "R11 soft reset aborts", busy, 0);
        cyc(8);
    endtask

    initial begin
        bit wd_fired;
        wd_fired = 1'b0;
        fork
            begin
                ctl_chan_master = 4'b0001;
                cyc(3);
                rst_n = 1'b1;
                enable = 1'b1;
                cyc(2);
                t_reset();
                t_single_word();
                t_short_burst();
                t_cross_word();
                t_stop_early();
                t_multi_burst();
                t_overflow();
                t_start_events();
                t_abort();
                chk(hs_err == 0, "R10 handshake order", hs_err, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule